// File: doc/BRIEF.md
# Cartridge Bus Write Latch with Busy Window

This block sits between a processor load/store port and a slow parallel cartridge bus. Each request carries a direction, an access size (byte, half, word or dword), an address and up to 64 bits of write data. A write that finds the bus free is forwarded downstream. Its data is also captured, already positioned, in a 32-bit latch, and a busy window of `BUSY_CYCLES` cycles (100 by default) opens. While that window is open the slow bus is assumed unable to take another transfer. Writes that arrive inside the window are thrown away. Reads that arrive inside it do not reach the bus: they return the latch contents and convert the rest of the window into a stall request towards the processor.

A three-state controller holds the window. The states are IDLE (bus free), BUSY (window open, `busy` high) and STALL (window handed to the processor as a stall, `stall` high).

- IDLE→BUSY is taken on an accepted write.
- BUSY→IDLE is taken when the countdown expires.
- BUSY→STALL is taken on a read while the window still has more than one cycle left.
- STALL→IDLE is taken when the countdown expires.

The countdown keeps running across the BUSY→STALL move, so `busy` or `stall` is high for exactly `BUSY_CYCLES` cycles after an accepted write. Reads that find the bus free are forwarded and answered one cycle later with the downstream data.

Top module: `xbus_wlatch`

## Requirements
- R1: A write (`req_write`=1) presented while `busy` and `stall` are low is forwarded in the same cycle on the `dn_*` port with unchanged size, address and data. `busy` then reads high for exactly `BUSY_CYCLES` consecutive cycles starting the cycle after, and falls by itself.
- R2: A write presented while `busy` is high is dropped. `dn_valid` stays low, the latch keeps its previous value, and the countdown is neither restarted nor extended.
- R3: A read (`req_write`=0) presented while `busy` is low is forwarded on the `dn_*` port in the same cycle. One cycle later `rsp_valid` is high and `rsp_rdata` equals the `dn_rdata` seen in the request cycle.
- R4: A read presented in the k-th cycle of the busy window (k from 1 to `BUSY_CYCLES`) is not forwarded. `busy` is low from the next cycle, and `stall` is high for the following `BUSY_CYCLES`−k cycles, then low. If k=`BUSY_CYCLES`, no stall occurs.
- R5: The response to a read under R4 comes one cycle later and is taken from the latch. Size code 0 (byte) gives latch[31:24] zero-extended. Code 1 (half) gives latch[31:16] zero-extended. Code 2 (word) gives the whole latch zero-extended. Code 3 (dword) gives the latch in bits [63:32] with zeros in [31:0].
- R6: A byte write puts data bits [7:0] in latch[31:24] when address bit 0 is 0, and in latch[23:16] when it is 1. All other latch bits are zero.
- R7: A half write puts data bits [15:0] in latch[31:16] with zeros below. A word write stores data bits [31:0]. A dword write stores only data bits [63:32].
- R8: After reset `busy`, `stall` and `rsp_valid` are low and the countdown is clear, so the first request is forwarded.
- R9: `busy` and `stall` are never high together, and no `dn_valid` is raised while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 dword |
| req_addr | input | AW (32) | Access address |
| req_wdata | input | 2*LW (64) | Write data, right-aligned |
| rsp_valid | output | 1 | Read response valid (one cycle after the read) |
| rsp_rdata | output | 2*LW (64) | Read response data |
| busy | output | 1 | Busy window open |
| stall | output | 1 | Stall request to the processor |
| dn_valid | output | 1 | Forwarded access strobe |
| dn_write | output | 1 | Forwarded direction |
| dn_size | output | 2 | Forwarded size |
| dn_addr | output | AW (32) | Forwarded address |
| dn_wdata | output | 2*LW (64) | Forwarded write data |
| dn_rdata | input | 2*LW (64) | Downstream read data, valid in the cycle of `dn_valid` |

## Verification
The properties assume that the processor honours `stall`: no request is presented while it is high, and an assertion states this assumption. They also assume that the downstream port answers a read combinationally in the same cycle. The bench drives every request from a task that first waits for `stall` to fall. It models the downstream side as a fixed function of `dn_addr`, so both assumptions hold for every stimulus pattern, including requests placed in the first and the last cycle of a busy window.

// File: rtl/xbl_pkg.sv
`timescale 1ns/1ps
package xbl_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        TS_IDLE  = 2'd0,
        TS_BUSY  = 2'd1,
        TS_STALL = 2'd2
    } tmr_state_e;
endpackage

// File: rtl/xbl_place.sv
`timescale 1ns/1ps
// Positions incoming write data inside the latch according to size.
module xbl_place #(
    parameter int LW = 32
) (
    input  logic [1:0]      size,
    input  logic            addr_lsb,
    input  logic [2*LW-1:0] wdata,
    output logic [LW-1:0]   lat_val
);
    import xbl_pkg::*;
    localparam int DW = 2 * LW;

    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE: begin
                if (addr_lsb)
                    lat_val = {8'h00, wdata[7:0], {(LW-16){1'b0}}};
                else
                    lat_val = {wdata[7:0], {(LW-8){1'b0}}};
            end
            SZ_HALF:  lat_val = {wdata[15:0], {(LW-16){1'b0}}};
            SZ_WORD:  lat_val = wdata[LW-1:0];
            SZ_DWORD: lat_val = wdata[DW-1:LW];
            default:  lat_val = '0;
        endcase
    end
endmodule

// File: rtl/xbl_view.sv
`timescale 1ns/1ps
// Forms the read reply taken from the latch for each access size.
module xbl_view #(
    parameter int LW = 32
) (
    input  logic [1:0]      size,
    input  logic [LW-1:0]   lat,
    output logic [2*LW-1:0] rdata
);
    import xbl_pkg::*;
    localparam int DW = 2 * LW;

    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE:  rdata = {{(DW-8){1'b0}}, lat[LW-1 -: 8]};
            SZ_HALF:  rdata = {{(DW-16){1'b0}}, lat[LW-1 -: 16]};
            SZ_WORD:  rdata = {{LW{1'b0}}, lat};
            SZ_DWORD: rdata = {lat, {LW{1'b0}}};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/xbl_timer.sv
`timescale 1ns/1ps
// Busy window controller: IDLE, BUSY, STALL with one shared countdown.
module xbl_timer #(
    parameter int BUSY_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_go,
    input  logic rd_hit,
    output logic busy,
    output logic stall
);
    import xbl_pkg::*;
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    tmr_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          last_cycle;

    assign last_cycle = (cnt_q == CW'(1));

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TS_IDLE: begin
                if (wr_go) begin
                    state_d = TS_BUSY;
                    cnt_d   = CW'(BUSY_CYCLES);
                end
            end
            TS_BUSY: begin
                cnt_d = cnt_q - CW'(1);
                if (last_cycle)
                    state_d = TS_IDLE;
                else if (rd_hit)
                    state_d = TS_STALL;
            end
            TS_STALL: begin
                cnt_d = cnt_q - CW'(1);
                if (last_cycle)
                    state_d = TS_IDLE;
            end
            default: begin
                state_d = TS_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        busy  = (state_q == TS_BUSY);
        stall = (state_q == TS_STALL);
    end

    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(BUSY_CYCLES));
    a_r8_idle_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_IDLE) |-> (cnt_q == '0));
    a_r2_busy_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != TS_IDLE) |=> (cnt_q != CW'(BUSY_CYCLES)));
endmodule

// File: rtl/xbus_wlatch.sv
`timescale 1ns/1ps
module xbus_wlatch #(
    parameter int AW          = 32,
    parameter int LW          = 32,
    parameter int BUSY_CYCLES = 100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [1:0]      req_size,
    input  logic [AW-1:0]   req_addr,
    input  logic [2*LW-1:0] req_wdata,
    output logic            rsp_valid,
    output logic [2*LW-1:0] rsp_rdata,
    output logic            busy,
    output logic            stall,
    output logic            dn_valid,
    output logic            dn_write,
    output logic [1:0]      dn_size,
    output logic [AW-1:0]   dn_addr,
    output logic [2*LW-1:0] dn_wdata,
    input  logic [2*LW-1:0] dn_rdata
);
    localparam int DW = 2 * LW;

    logic          wr_go, rd_hit;
    logic [LW-1:0] latch_q, lat_new;
    logic [DW-1:0] lat_view;
    logic          rsp_valid_q;
    logic [DW-1:0] rsp_rdata_q;

    assign wr_go  = req_valid &  req_write & ~busy;
    assign rd_hit = req_valid & ~req_write &  busy;

    xbl_place #(.LW(LW)) u_place (
        .size     (req_size),
        .addr_lsb (req_addr[0]),
        .wdata    (req_wdata),
        .lat_val  (lat_new)
    );

    xbl_view #(.LW(LW)) u_view (
        .size  (req_size),
        .lat   (latch_q),
        .rdata (lat_view)
    );

    xbl_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_go  (wr_go),
        .rd_hit (rd_hit),
        .busy   (busy),
        .stall  (stall)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q     <= '0;
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            if (wr_go)
                latch_q <= lat_new;
            rsp_valid_q <= req_valid & ~req_write;
            if (req_valid & ~req_write)
                rsp_rdata_q <= rd_hit ? lat_view : dn_rdata;
        end
    end

    assign dn_valid  = req_valid & ~busy;
    assign dn_write  = req_write;
    assign dn_size   = req_size;
    assign dn_addr   = req_addr;
    assign dn_wdata  = req_wdata;
    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rsp_rdata_q;

    a_r9_no_fwd_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !dn_valid);
    a_r9_busy_stall_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && stall));
    a_r9_no_req_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !req_valid);
    a_r1_write_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !busy && !stall) |=> busy);
    a_r2_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write && !busy) |=> $stable(latch_q));
    a_r4_read_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && busy) |=> !busy);
    a_r3_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);
endmodule

// File: tb/sim_xbus_wlatch.sv
`timescale 1ns/1ps
module sim_xbus_wlatch;
    localparam int AW = 32;
    localparam int LW = 32;
    localparam int DW = 64;
    localparam int BC = 100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]    req_size = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid, busy, stall, dn_valid, dn_write;
    logic [DW-1:0] rsp_rdata, dn_wdata, dn_rdata;
    logic [1:0]    dn_size;
    logic [AW-1:0] dn_addr;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    always #2.5 clk = ~clk;

    assign dn_rdata = {32'hCAFE0000, dn_addr};

    xbus_wlatch #(.AW(AW), .LW(LW), .BUSY_CYCLES(BC)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy), .stall(stall),
        .dn_valid(dn_valid), .dn_write(dn_write), .dn_size(dn_size),
        .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops scoreboard on every response.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk("R3 unexpected response", 64'd1, 64'd0);
            end else begin
                chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    // Driver: one request for one cycle; called at a negedge.
    task automatic issue(input logic wr, input logic [1:0] sz, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, input logic exp_fwd,
                         input logic [DW-1:0] exp_rd, input string tag);
        while (stall) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
        #1;
        chk({tag, " dn_valid"}, {63'd0, dn_valid}, {63'd0, exp_fwd});
        if (exp_fwd) begin
            chk({tag, " dn fields"}, {dn_write, dn_size, dn_addr[28:0], dn_wdata[31:0]},
                {wr, sz, a[28:0], wd[31:0]});
        end
        if (!wr) begin
            exp_q.push_back(exp_rd);
            tag_q.push_back({tag, " rdata"});
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic count_high(input logic which_stall, output int n);
        n = 0;
        while ((which_stall ? stall : busy) && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic settle();
        while (busy || stall) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 busy after reset", {63'd0, busy}, 64'd0);
        chk("R8 stall after reset", {63'd0, stall}, 64'd0);
        chk("R8 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: idle read forwarded, answered from downstream
        issue(1'b0, 2'd2, 32'h0000_0100, '0, 1'b1, {32'hCAFE0000, 32'h0000_0100}, "R3 idle read");
        issue(1'b0, 2'd3, 32'h1000_0008, '0, 1'b1, {32'hCAFE0000, 32'h1000_0008}, "R3 idle dword read");

        // R1: write forwarded, busy window length
        issue(1'b1, 2'd2, 32'h1000_0000, 64'h0000_0000_1122_3344, 1'b1, '0, "R1 word write");
        count_high(1'b0, n);
        chk("R1 busy window length", 64'(n), 64'(BC));
        chk("R1 stall stays low", {63'd0, stall}, 64'd0);
        @(negedge clk);

        // R2 + R4 + R5: dropped write, read returns latch, stall length
        issue(1'b1, 2'd2, 32'h1000_0004, 64'h0000_0000_AABB_CCDD, 1'b1, '0, "R1 second write");
        issue(1'b1, 2'd2, 32'h1000_0008, 64'h0000_0000_5555_5555, 1'b0, '0, "R2 write while busy");
        issue(1'b0, 2'd2, 32'h1000_000C, '0, 1'b0, 64'h0000_0000_AABB_CCDD, "R2 R5 word read from latch");
        chk("R4 busy cleared by read", {63'd0, busy}, 64'd0);
        count_high(1'b1, n);
        chk("R4 stall length after read in cycle 2", 64'(n), 64'(BC - 2));
        settle();

        // R6: byte placement, even and odd address
        issue(1'b1, 2'd0, 32'h2000_0000, 64'hFFFF_FFFF_FFFF_FFAB, 1'b1, '0, "R6 byte write even");
        issue(1'b0, 2'd2, 32'h2000_0000, '0, 1'b0, 64'h0000_0000_AB00_0000, "R6 even byte in latch");
        count_high(1'b1, n);
        chk("R4 stall length after read in cycle 1", 64'(n), 64'(BC - 1));
        settle();
        issue(1'b1, 2'd0, 32'h2000_0001, 64'h0000_0000_0000_00CD, 1'b1, '0, "R6 byte write odd");
        issue(1'b0, 2'd2, 32'h2000_0000, '0, 1'b0, 64'h0000_0000_00CD_0000, "R6 odd byte in latch");
        settle();
        issue(1'b1, 2'd0, 32'h2000_0001, 64'h0000_0000_0000_00CD, 1'b1, '0, "R6 byte write odd again");
        issue(1'b0, 2'd0, 32'h2000_0000, '0, 1'b0, 64'h0000_0000_0000_0000, "R5 byte view of odd byte");
        settle();

        // R7 + R5: half, dword placement and views
        issue(1'b1, 2'd1, 32'h3000_0002, 64'h0000_0000_1234_BEEF, 1'b1, '0, "R7 half write");
        issue(1'b0, 2'd1, 32'h3000_0002, '0, 1'b0, 64'h0000_0000_0000_BEEF, "R5 half view");
        settle();
        issue(1'b1, 2'd1, 32'h3000_0002, 64'h0000_0000_1234_BEEF, 1'b1, '0, "R7 half write again");
        issue(1'b0, 2'd2, 32'h3000_0000, '0, 1'b0, 64'h0000_0000_BEEF_0000, "R7 half placement");
        settle();
        issue(1'b1, 2'd3, 32'h3000_0008, 64'h0123_4567_89AB_CDEF, 1'b1, '0, "R7 dword write");
        issue(1'b0, 2'd3, 32'h3000_0008, '0, 1'b0, 64'h0123_4567_0000_0000, "R5 R7 dword view");
        settle();
        issue(1'b1, 2'd3, 32'h3000_0008, 64'h0123_4567_89AB_CDEF, 1'b1, '0, "R7 dword write again");
        issue(1'b0, 2'd0, 32'h3000_0008, '0, 1'b0, 64'h0000_0000_0000_0001, "R5 byte view after dword");
        settle();

        // R4 boundary: read in the last busy cycle, no stall
        issue(1'b1, 2'd2, 32'h4000_0000, 64'h0000_0000_7777_8888, 1'b1, '0, "R1 write for last-cycle read");
        idle(BC - 1);
        chk("R4 still busy in last cycle", {63'd0, busy}, 64'd1);
        issue(1'b0, 2'd2, 32'h4000_0000, '0, 1'b0, 64'h0000_0000_7777_8888, "R4 last-cycle read");
        chk("R4 no stall after last-cycle read", {63'd0, stall}, 64'd0);
        chk("R4 busy low after last-cycle read", {63'd0, busy}, 64'd0);
        @(negedge clk);

        // R2 boundary: write in last busy cycle dropped, window not extended
        issue(1'b1, 2'd2, 32'h5000_0000, 64'h0000_0000_1357_9BDF, 1'b1, '0, "R1 write for last-cycle drop");
        idle(BC - 1);
        issue(1'b1, 2'd2, 32'h5000_0004, 64'h0000_0000_2468_ACE0, 1'b0, '0, "R2 last-cycle write");
        chk("R2 window not extended", {62'd0, busy, stall}, 64'd0);
        issue(1'b0, 2'd2, 32'h5000_0004, '0, 1'b1, {32'hCAFE0000, 32'h5000_0004}, "R3 read after window");
        @(negedge clk);
        @(negedge clk);
        chk("R3 scoreboard drained", 64'(exp_q.size()), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule